// File: doc/BRIEF.md
# Manchester Bit-Timing Recovery with Drift Correction

This block recovers bit timing from a Manchester-coded receive line. The line is already synchronised and is sampled at sixteen times the bit rate, with each sample marked by a one-clock enable. A bit-period counter predicts where the mid-bit transition should fall. The first transition seen near that point is compared with the prediction. An offset of one sample is treated as jitter and left alone. A somewhat larger offset is treated as drift, and the current bit is made one sample shorter or longer. Any other offset inside the inspection window is reported as a timing error.

Each recovered bit produces one strobe, together with the line level taken three quarters of the way through the bit. Sync detection and character assembly happen downstream and are not part of this block.

Samples within a bit are numbered from 0. The first sample accepted after reset is number 0 of the first bit. A bit of period P ends with sample P-1, and the following sample is number 0 of the next bit. An edge at sample i means the level at sample i differs from the level at the previous sample. The predicted edge is sample 8, so an edge at sample i has offset i-8.

Top module: `mdc_rx_drift`

## Requirements
- R1: While reset is asserted, and directly after it, bit_stb, tim_err and bit_val are 0, and the next accepted sample is number 0 of a new bit.
- R2: With no correction, a bit lasts 16 samples. bit_stb is high for exactly one clock, the clock after sample 12 of every bit, and at no other time.
- R3: bit_val takes the rxd level of sample 12 in the same clock that bit_stb rises, and holds that value until the next strobe.
- R4: A first judged edge at sample 7, 8 or 9 (offset -1..+1) leaves the period at 16 and does not raise tim_err.
- R5: With comp_en high, a first judged edge at sample 4, 5 or 6 (2 to 4 early) shortens that bit to 15 samples.
- R6: With comp_en high, a first judged edge at sample 10 or 11 (2 or 3 late) lengthens that bit to 17 samples.
- R7: A first judged edge at sample 2, 3, 12 or 13 makes tim_err high for one clock, the clock after that sample. Such an edge applies no correction.
- R8: Edges at samples 0, 1 and 14 onward are ignored. They cause no correction and no tim_err.
- R9: Only the first edge in samples 2..13 of a bit is judged. Later edges in the same bit are ignored, so a bit's period moves by at most one sample.
- R10: With comp_en low when the edge is judged, the period stays at 16. The tim_err check of R7 still applies.
- R11: Changes of rxd during clocks where smp_en is low have no effect on timing, strobe or bit value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_en | input | 1 | One-clock pulse marking each 16x sample |
| rxd | input | 1 | Synchronised receive line |
| comp_en | input | 1 | Enables period correction |
| bit_stb | output | 1 | One-clock pulse per recovered bit |
| bit_val | output | 1 | Decoded bit value (second-half level) |
| tim_err | output | 1 | One-clock pulse for an out-of-window edge |

## Verification
The hardest case to reach from the ports is a bit holding several edges inside the judging window, where only the first may steer the period. The stimulus injects a one-sample glitch just after a drift-inducing mid-bit edge. A design that judged a later edge would then shift the next strobe by a sample. Every stimulus bit is laid over the bit boundaries the requirements predict. Because of this, a wrong period in any bit moves the strobe off sample 12 of every bit that follows. Further runs toggle rxd between sample enables and apply reset in the middle of a bit.

// File: rtl/mdc_pkg.sv
package mdc_pkg;

  typedef enum logic [1:0] {
    ADJ_NONE  = 2'd0,
    ADJ_SHORT = 2'd1,
    ADJ_LONG  = 2'd2
  } adj_e;

  typedef enum logic [2:0] {
    PH_OUTSIDE = 3'd0,
    PH_JITTER  = 3'd1,
    PH_EARLY   = 3'd2,
    PH_LATE    = 3'd3,
    PH_FAULT   = 3'd4
  } phase_e;

  // Sort an edge offset (observed minus predicted sample) into a class.
  function automatic phase_e classify(input int offset,
                                      input int early_lo, input int early_hi,
                                      input int late_lo, input int late_hi,
                                      input int guard_e, input int guard_l);
    if (offset < -guard_e || offset > guard_l)          return PH_OUTSIDE;
    if (offset <= -early_lo && offset >= -early_hi)      return PH_EARLY;
    if (offset >= late_lo && offset <= late_hi)          return PH_LATE;
    if (offset > -early_lo && offset < late_lo)          return PH_JITTER;
    return PH_FAULT;
  endfunction

  // Final sample index of a bit, given the correction in force.
  function automatic int period_last(input int osr, input adj_e a);
    case (a)
      ADJ_SHORT: return osr - 2;
      ADJ_LONG:  return osr;
      default:   return osr - 1;
    endcase
  endfunction

endpackage

// File: rtl/mdc_edge_det.sv
module mdc_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_en,
  input  logic rxd,
  output logic edge_seen
);
  logic prev_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      prev_lvl <= 1'b1;
    else if (smp_en) prev_lvl <= rxd;
  end

  assign edge_seen = smp_en && (rxd != prev_lvl);

  // R11: the stored level only moves on a sample
  assert_prev_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en |=> $stable(prev_lvl));
endmodule

// File: rtl/mdc_bit_timer.sv
module mdc_bit_timer
  import mdc_pkg::*;
#(
  parameter int OSR = 16,
  parameter int CW  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_en,
  input  adj_e          adj,
  output logic [CW-1:0] cnt,
  output logic          wrap
);
  logic [CW-1:0] last_idx;

  always_comb last_idx = CW'(period_last(OSR, adj));
  assign wrap = (cnt == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (smp_en) cnt <= wrap ? '0 : cnt + 1'b1;
  end

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(OSR));
  assert_wrap_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && wrap) |=> (cnt == '0));
  assert_cnt_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en |=> $stable(cnt));
endmodule

// File: rtl/mdc_phase_cmp.sv
module mdc_phase_cmp
  import mdc_pkg::*;
#(
  parameter int OSR       = 16,
  parameter int CW        = 5,
  parameter int EARLY_MIN = 2,
  parameter int EARLY_MAX = 4,
  parameter int LATE_MIN  = 2,
  parameter int LATE_MAX  = 3,
  parameter int GUARD_E   = 6,
  parameter int GUARD_L   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_en,
  input  logic          edge_seen,
  input  logic [CW-1:0] cnt,
  input  logic          wrap,
  input  logic          comp_en,
  output adj_e          adj,
  output logic          fault
);
  localparam int MID = OSR / 2;

  logic   seen;
  phase_e cls;
  logic   judge;

  always_comb cls = classify(int'(cnt) - MID, EARLY_MIN, EARLY_MAX,
                             LATE_MIN, LATE_MAX, GUARD_E, GUARD_L);
  assign judge = edge_seen && !seen && !wrap && (cls != PH_OUTSIDE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen  <= 1'b0;
      adj   <= ADJ_NONE;
      fault <= 1'b0;
    end else begin
      fault <= judge && (cls == PH_FAULT);
      if (smp_en && wrap) begin
        seen <= 1'b0;
        adj  <= ADJ_NONE;
      end else if (judge) begin
        seen <= 1'b1;
        if (comp_en && cls == PH_EARLY)     adj <= ADJ_SHORT;
        else if (comp_en && cls == PH_LATE) adj <= ADJ_LONG;
      end
    end
  end

  // R9: once set, a correction holds until the bit ends
  assert_one_fix_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (adj != ADJ_NONE && !(smp_en && wrap)) |=> adj == $past(adj));
  assert_fault_no_fix_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> adj == ADJ_NONE);
  assert_comp_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (judge && !comp_en) |=> adj == ADJ_NONE);
endmodule

// File: rtl/mdc_rx_drift.sv
module mdc_rx_drift
  import mdc_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int EARLY_MIN   = 2,
  parameter int EARLY_MAX   = 4,
  parameter int LATE_MIN    = 2,
  parameter int LATE_MAX    = 3,
  parameter int GUARD_EARLY = 6,
  parameter int GUARD_LATE  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_en,
  input  logic rxd,
  input  logic comp_en,
  output logic bit_stb,
  output logic bit_val,
  output logic tim_err
);
  localparam int MID       = OSR / 2;
  localparam int SAMPLE_AT = MID + OSR / 4;
  localparam int CW        = $clog2(OSR + 2);

  logic          edge_seen;
  logic [CW-1:0] cnt;
  logic          wrap;
  adj_e          adj;

  mdc_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .rxd(rxd), .edge_seen(edge_seen)
  );

  mdc_bit_timer #(.OSR(OSR), .CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .adj(adj), .cnt(cnt), .wrap(wrap)
  );

  mdc_phase_cmp #(
    .OSR(OSR), .CW(CW), .EARLY_MIN(EARLY_MIN), .EARLY_MAX(EARLY_MAX),
    .LATE_MIN(LATE_MIN), .LATE_MAX(LATE_MAX),
    .GUARD_E(GUARD_EARLY), .GUARD_L(GUARD_LATE)
  ) u_phase (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .edge_seen(edge_seen),
    .cnt(cnt), .wrap(wrap), .comp_en(comp_en), .adj(adj), .fault(tim_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_stb <= 1'b0;
      bit_val <= 1'b0;
    end else begin
      bit_stb <= smp_en && (cnt == CW'(SAMPLE_AT));
      if (smp_en && cnt == CW'(SAMPLE_AT)) bit_val <= rxd;
    end
  end

  assert_stb_after_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |-> $past(smp_en));
  assert_stb_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |=> !bit_stb);
  assert_err_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tim_err |=> !tim_err);
  assert_val_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> $stable(bit_val) || bit_stb);
endmodule

// File: tb/tb_mdc_rx_drift.sv
`timescale 1ns/1ps
module tb_mdc_rx_drift;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_en = 1'b0;
  logic rxd = 1'b1;
  logic comp_en = 1'b1;
  logic bit_stb, bit_val, tim_err;

  int total = 0;
  int bad = 0;
  bit noisy = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mdc_rx_drift dut (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .rxd(rxd), .comp_en(comp_en),
    .bit_stb(bit_stb), .bit_val(bit_val), .tim_err(tim_err)
  );

  // {bit, comp, glitch sample (0 = none), mid-edge sample}
  localparam int NV = 21;
  localparam logic [11:0] VEC [NV] = '{
    {1'b0, 1'b1, 5'd0,  5'd8},  {1'b1, 1'b1, 5'd0,  5'd8},
    {1'b1, 1'b1, 5'd0,  5'd7},  {1'b0, 1'b1, 5'd0,  5'd9},
    {1'b1, 1'b1, 5'd0,  5'd4},  {1'b0, 1'b1, 5'd0,  5'd6},
    {1'b1, 1'b1, 5'd0,  5'd5},  {1'b0, 1'b1, 5'd0,  5'd10},
    {1'b1, 1'b1, 5'd0,  5'd11}, {1'b0, 1'b1, 5'd0,  5'd2},
    {1'b1, 1'b1, 5'd0,  5'd3},  {1'b0, 1'b1, 5'd0,  5'd12},
    {1'b1, 1'b1, 5'd0,  5'd13}, {1'b0, 1'b1, 5'd14, 5'd8},
    {1'b1, 1'b1, 5'd0,  5'd8},  {1'b0, 1'b1, 5'd6,  5'd5},
    {1'b1, 1'b1, 5'd11, 5'd10}, {1'b0, 1'b0, 5'd0,  5'd5},
    {1'b1, 1'b0, 5'd0,  5'd11}, {1'b0, 1'b0, 5'd0,  5'd13},
    {1'b1, 1'b1, 5'd0,  5'd8}
  };

  function automatic bit exp_err(input int m);
    return (m == 2 || m == 3 || m == 12 || m == 13);
  endfunction

  function automatic int exp_adj(input int m, input bit comp);
    if (!comp) return 0;
    if (m >= 4 && m <= 6) return -1;
    if (m == 10 || m == 11) return 1;
    return 0;
  endfunction

  function automatic bit lvl(input bit b, input int m, input int g, input int i);
    bit v;
    v = (i >= m) ? b : !b;
    if (g != 0 && i == g) v = !v;
    return v;
  endfunction

  function automatic string tag_of(input int m, input bit comp, input int g);
    if (g >= 14) return "R8";
    if (g != 0) return "R9";
    if (!comp) return "R10";
    if (exp_err(m)) return "R7";
    if (exp_adj(m, comp) < 0) return "R5";
    if (exp_adj(m, comp) > 0) return "R6";
    if (m != 8) return "R4";
    return "R2";
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic send_sample(input bit v);
    @(negedge clk);
    rxd = v;
    smp_en = 1'b1;
    @(negedge clk);
    smp_en = 1'b0;
    if (noisy) rxd = !v;
  endtask

  task automatic run_bit(input bit b, input bit comp, input int g, input int m,
                         input string tag);
    int p;
    comp_en = comp;
    p = 16 + exp_adj(m, comp);
    for (int i = 0; i < p; i++) begin
      send_sample(lvl(b, m, g, i));
      chk(bit_stb == (i == 12), (tag == "R11") ? "R11" : "R2",
          int'(bit_stb), int'(i == 12));
      chk(tim_err == (exp_err(m) && i == m), tag, int'(tim_err),
          int'(exp_err(m) && i == m));
      if (i == 12) chk(bit_val == lvl(b, m, g, 12), "R3", int'(bit_val),
                       int'(lvl(b, m, g, 12)));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(bit_stb == 0 && tim_err == 0 && bit_val == 0, "R1",
        int'({bit_stb, tim_err, bit_val}), 0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      run_bit(VEC[v][11], VEC[v][10], int'(VEC[v][9:5]), int'(VEC[v][4:0]),
              tag_of(int'(VEC[v][4:0]), VEC[v][10], int'(VEC[v][9:5])));
    end

    // R11: line toggles between sample enables
    noisy = 1'b1;
    run_bit(1'b0, 1'b1, 0, 5, "R11");
    run_bit(1'b1, 1'b1, 0, 10, "R11");
    run_bit(1'b1, 1'b1, 0, 8, "R11");
    noisy = 1'b0;

    // R1: reset in the middle of a bit
    for (int i = 0; i < 5; i++) send_sample(lvl(1'b1, 8, 0, i));
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(bit_stb == 0 && tim_err == 0 && bit_val == 0, "R1",
        int'({bit_stb, tim_err, bit_val}), 0);
    rst_n = 1'b1;
    run_bit(1'b0, 1'b1, 0, 8, "R1");
    run_bit(1'b1, 1'b1, 0, 6, "R1");
    run_bit(1'b0, 1'b1, 0, 8, "R1");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule